// File: doc/BRIEF.md
# Periodic-Pattern Stimulus Sequencer

This block is a built-in stimulus source for the primary inputs of a sequential circuit under test. It holds a fixed table of weight assignments. Each assignment names one short periodic bit pattern for every primary input. A run applies the assignments one after another. Each assignment drives the inputs for a segment of `SEG_LEN` clock cycles, and then the next one takes over. Every input value comes from a repeated deterministic pattern. No pseudo-random source is used.

Patterns of equal length share one modulo counter, which acts as that length's pattern FSM. All of these counters return to phase 0 when a run is accepted and at every segment boundary. Each primary input has its own multiplexer across the assignments. One segment counter drives the select of all these multiplexers. After the final segment the block raises `done` and drives the stimulus low until a new run is started.

Top module: `wsg_gen`

## Requirements
- R1: While reset is applied and after it is released, `stim` is all zeros, `seg_idx` is 0 and `done` is 0.
- R2: When `start` is high at a clock edge with no run in progress, a run begins. In the cycle after that edge, `seg_idx` is 0 and each input `i` carries bit 0 of the pattern of assignment 0 for input `i`.
- R3: In segment `s`, at offset `t` cycles from the segment's first cycle, input `i` carries bit `t mod len` of the pattern for `(s,i)`. Pattern `(s,i)` sits at slot `k = s*N_IN + i`. Its bits are `PAT_BITS[k*MAX_PLEN +: MAX_PLEN]`, with bit position equal to phase. Its length (1..MAX_PLEN) is `PAT_LEN[k*LW +: LW]`.
- R4: Each segment lasts exactly `SEG_LEN` cycles. `seg_idx` then increases by one, and it stays stable inside a segment.
- R5: Every segment starts its patterns at phase 0, even when `SEG_LEN` is not a multiple of a pattern's length.
- R6: After the last segment (index `N_ASG-1`) ends, `done` goes high and stays high, while `stim` is 0 and `seg_idx` is 0. This holds until the next accepted `start`.
- R7: A `start` pulse during a run has no effect on the stimulus, the segment index or the schedule.
- R8: A `start` after `done` clears `done` and repeats the whole run identically.
- R9: A pattern of length 1 holds its single bit constant for the whole segment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a run when no run is in progress |
| stim | output | N_IN | Stimulus bus to the circuit's primary inputs |
| seg_idx | output | SW | Index of the active assignment |
| done | output | 1 | Set once the last segment has finished |

## Verification
The bench uses a segment length of 7 together with pattern lengths of 1 to 4. Most periods therefore do not divide the segment. A design that let its phase counters run freely across a boundary would start the next segment mid-pattern and show wrong bits at offset 0. Every cycle of two full runs is compared against an arithmetic model. This catches an off-by-one segment length, a skipped or repeated segment, or a mux that picks the wrong slot. The bench also raises `start` in the middle of a run; a design that restarted on it would jump `seg_idx` back to 0. After the run ends, the bench checks that `done` holds and the bus stays at zero, and then checks that a restart reproduces the first run.

// File: rtl/wsg_pkg.sv
package wsg_pkg;
  // width needed to hold values 0..n-1, never below one bit
  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/wsg_phase_ctr.sv
module wsg_phase_ctr #(
  parameter int LEN = 2,
  parameter int IW  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          adv,
  output logic [IW-1:0] phase
);
  localparam logic [IW-1:0] LAST = IW'(LEN - 1);

  logic          en;
  logic [IW-1:0] phase_n;

  always_comb begin
    en = clr | adv;
    if (clr || phase == LAST) phase_n = '0;
    else                      phase_n = phase + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  phase <= '0;
    else if (en) phase <= phase_n;
  end
endmodule

// File: rtl/wsg_seg_timer.sv
module wsg_seg_timer
  import wsg_pkg::*;
#(
  parameter int N_ASG   = 4,
  parameter int SEG_LEN = 2000,
  localparam int SW = idx_bits(N_ASG),
  localparam int CW = idx_bits(SEG_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          run,
  output logic [SW-1:0] seg,
  output logic          done,
  output logic          last_cyc,
  output logic          restart
);
  logic [CW-1:0] cyc, cyc_n;
  logic [SW-1:0] seg_n;
  logic          run_n, done_n, go, last_seg, en;

  always_comb begin
    go       = start & ~run;
    last_cyc = (cyc == CW'(SEG_LEN - 1));
    last_seg = (seg == SW'(N_ASG - 1));
    restart  = go | (run & last_cyc);
    en       = go | run;
    run_n    = run;
    seg_n    = seg;
    cyc_n    = cyc;
    done_n   = done;
    if (go) begin
      run_n  = 1'b1;
      seg_n  = '0;
      cyc_n  = '0;
      done_n = 1'b0;
    end else if (run) begin
      if (last_cyc) begin
        cyc_n = '0;
        if (last_seg) begin
          run_n  = 1'b0;
          done_n = 1'b1;
          seg_n  = '0;
        end else begin
          seg_n = seg + 1'b1;
        end
      end else begin
        cyc_n = cyc + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run  <= 1'b0;
      seg  <= '0;
      cyc  <= '0;
      done <= 1'b0;
    end else if (en) begin
      run  <= run_n;
      seg  <= seg_n;
      cyc  <= cyc_n;
      done <= done_n;
    end
  end
endmodule

// File: rtl/wsg_lane.sv
module wsg_lane
  import wsg_pkg::*;
#(
  parameter int N_IN     = 3,
  parameter int N_ASG    = 4,
  parameter int MAX_PLEN = 4,
  parameter int LANE     = 0,
  localparam int SW = idx_bits(N_ASG),
  localparam int IW = idx_bits(MAX_PLEN),
  localparam int LW = $clog2(MAX_PLEN + 1),
  parameter logic [N_ASG*N_IN*LW-1:0]       PAT_LEN  = '1,
  parameter logic [N_ASG*N_IN*MAX_PLEN-1:0] PAT_BITS = '0
) (
  input  logic                   run,
  input  logic [SW-1:0]          seg,
  input  logic [MAX_PLEN*IW-1:0] phase_flat,
  output logic                   bit_o
);
  logic [N_ASG-1:0] cand;

  always_comb begin
    for (int a = 0; a < N_ASG; a++) begin
      logic [LW-1:0]       plen;
      logic [MAX_PLEN-1:0] pbits;
      logic [IW-1:0]       ph;
      plen    = PAT_LEN[(a*N_IN + LANE)*LW +: LW];
      pbits   = PAT_BITS[(a*N_IN + LANE)*MAX_PLEN +: MAX_PLEN];
      ph      = '0;
      cand[a] = 1'b0;
      for (int l = 0; l < MAX_PLEN; l++)
        if (plen == LW'(l + 1)) ph = phase_flat[l*IW +: IW];
      for (int k = 0; k < MAX_PLEN; k++)
        if (ph == IW'(k)) cand[a] = pbits[k];
    end
    bit_o = 1'b0;
    for (int a = 0; a < N_ASG; a++)
      if (run && seg == SW'(a)) bit_o = cand[a];
  end
endmodule

// File: rtl/wsg_gen.sv
module wsg_gen
  import wsg_pkg::*;
#(
  parameter int N_IN     = 3,
  parameter int N_ASG    = 4,
  parameter int SEG_LEN  = 2000,
  parameter int MAX_PLEN = 4,
  localparam int SW = idx_bits(N_ASG),
  localparam int IW = idx_bits(MAX_PLEN),
  localparam int LW = $clog2(MAX_PLEN + 1),
  parameter logic [N_ASG*N_IN*LW-1:0]       PAT_LEN  = 36'o132421314213,
  parameter logic [N_ASG*N_IN*MAX_PLEN-1:0] PAT_BITS = 48'h9E36B1C472D8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  output logic [N_IN-1:0] stim,
  output logic [SW-1:0]   seg_idx,
  output logic            done
);
  logic                   run, last_cyc, restart;
  logic [MAX_PLEN*IW-1:0] phase_flat;

  wsg_seg_timer #(.N_ASG(N_ASG), .SEG_LEN(SEG_LEN)) timer_i (
    .clk(clk), .rst_n(rst_n), .start(start), .run(run), .seg(seg_idx),
    .done(done), .last_cyc(last_cyc), .restart(restart)
  );

  // one pattern FSM per period length, shared by all patterns of that length
  for (genvar l = 1; l <= MAX_PLEN; l++) begin : g_len
    wsg_phase_ctr #(.LEN(l), .IW(IW)) ctr_i (
      .clk(clk), .rst_n(rst_n), .clr(restart), .adv(run),
      .phase(phase_flat[(l-1)*IW +: IW])
    );
  end

  for (genvar i = 0; i < N_IN; i++) begin : g_lane
    wsg_lane #(
      .N_IN(N_IN), .N_ASG(N_ASG), .MAX_PLEN(MAX_PLEN), .LANE(i),
      .PAT_LEN(PAT_LEN), .PAT_BITS(PAT_BITS)
    ) lane_i (
      .run(run), .seg(seg_idx), .phase_flat(phase_flat), .bit_o(stim[i])
    );
  end
endmodule

// File: rtl/wsg_gen_chk.sv
module wsg_gen_chk
  import wsg_pkg::*;
#(
  parameter int N_IN     = 3,
  parameter int N_ASG    = 4,
  parameter int MAX_PLEN = 4,
  localparam int SW = idx_bits(N_ASG),
  localparam int IW = idx_bits(MAX_PLEN)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   start,
  input logic [N_IN-1:0]        stim,
  input logic [SW-1:0]          seg_idx,
  input logic                   done,
  input logic                   run,
  input logic                   last_cyc,
  input logic                   restart,
  input logic [MAX_PLEN*IW-1:0] phase_flat
);
  a_r4_seg_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !last_cyc && !start) |=> $stable(seg_idx));

  a_r4_seg_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && last_cyc && seg_idx != SW'(N_ASG - 1)) |=> (seg_idx == $past(seg_idx) + 1'b1));

  a_r5_phase_clear: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (phase_flat == '0));

  a_r6_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(seg_idx) == SW'(N_ASG - 1)));

  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (stim == '0 && seg_idx == '0));

  a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (run && start && !last_cyc) |=> run);
endmodule

bind wsg_gen wsg_gen_chk #(.N_IN(N_IN), .N_ASG(N_ASG), .MAX_PLEN(MAX_PLEN)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .stim(stim), .seg_idx(seg_idx),
  .done(done), .run(run), .last_cyc(last_cyc), .restart(restart),
  .phase_flat(phase_flat)
);

// File: tb/wsg_gen_tb.sv
module wsg_gen_tb_top;
  localparam int N_IN     = 3;
  localparam int N_ASG    = 4;
  localparam int SEG_LEN  = 7;
  localparam int MAX_PLEN = 4;
  localparam int SW = 2;
  localparam int LW = 3;
  localparam logic [N_ASG*N_IN*LW-1:0]       PLEN  = 36'o132421314213;
  localparam logic [N_ASG*N_IN*MAX_PLEN-1:0] PBITS = 48'h9E36B1C472D8;

  logic            clk, rst_n, start;
  logic [N_IN-1:0] stim;
  logic [SW-1:0]   seg_idx;
  logic            done;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  wsg_gen #(.N_IN(N_IN), .N_ASG(N_ASG), .SEG_LEN(SEG_LEN), .MAX_PLEN(MAX_PLEN),
            .PAT_LEN(PLEN), .PAT_BITS(PBITS)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .stim(stim),
    .seg_idx(seg_idx), .done(done)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int plen_of(input int s, input int i);
    return int'(PLEN[(s*N_IN + i)*LW +: LW]);
  endfunction

  function automatic int exp_bit(input int s, input int i, input int off);
    return int'(PBITS[(s*N_IN + i)*MAX_PLEN + (off % plen_of(s, i))]);
  endfunction

  // start accepted at one edge; every following negedge is one run cycle
  task automatic do_run(input int poke_at, input string rtag);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int t = 0; t < N_ASG*SEG_LEN; t++) begin
      int s, off;
      s   = t / SEG_LEN;
      off = t % SEG_LEN;
      check((t == poke_at + 1) ? "R7 seg" : "R4 seg", int'(seg_idx), s);
      check("R6 done low in run", int'(done), 0);
      for (int i = 0; i < N_IN; i++) begin
        string tg;
        if (off == 0)                tg = (s == 0) ? "R2 first bit" : "R5 boundary phase";
        else if (plen_of(s, i) == 1) tg = "R9 const";
        else                         tg = "R3 bit";
        check({rtag, " ", tg}, int'(stim[i]), exp_bit(s, i, off));
      end
      start = (t == poke_at);
      @(negedge clk);
    end
    start = 1'b0;
    for (int k = 0; k < 5; k++) begin
      check({rtag, " R6 done"}, int'(done), 1);
      check({rtag, " R6 stim zero"}, int'(stim), 0);
      check({rtag, " R6 seg zero"}, int'(seg_idx), 0);
      @(negedge clk);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    #1;
    check("R1 stim", int'(stim), 0);
    check("R1 seg", int'(seg_idx), 0);
    check("R1 done", int'(done), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 stim after release", int'(stim), 0);
    check("R1 done after release", int'(done), 0);
    do_run(-1, "run1");
    do_run(12, "R8 rerun R7 poke");
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5 * 20000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule